// File: doc/BRIEF.md
# Carrier status register bank

This block is a bus-slave register bank for a carrier board. It presents eight 32-bit read words: board identity taken from strap pins, a 64-bit silicon identity delivered once by an external sensor reader, bitstream identity and build time fixed by parameters, the latest temperature sample, a live status word, and one read/write control word whose halves drive the adjustable mezzanine supply code and the system clock selection.

A prescaler derived from the clock-frequency parameter asks the sensor reader for a new temperature once per second. The reader answers with a valid strobe and a signed fixed-point sample with four fractional bits. Every sample above the alarm threshold (60 degrees, so 960 in raw units) produces a single-cycle alarm pulse that an interrupt controller can pick up. The one-wire protocol engine, the supply sensing and the supply or clock hardware sit outside the block.

Top module: `carrier_status_regs`

## Requirements
- R1: After reset, wb_ack_o, sens_temp_req_o and temp_alarm_o are 0, the control word equals CTRL_RST, and the temperature and silicon ID words read 0.
- R2: Word offset 0 reads {board_type_i, pcb_ver_i}, with the board type in bits [31:16] and the PCB version in bits [15:0].
- R3: Offsets 1 and 2 read the low and high 32 bits of the silicon ID presented with the first sens_id_vld_i strobe after reset; later strobes leave both words unchanged.
- R4: Offset 3 reads {BS_TYPE, BS_VER} (type in [31:16]) and offset 4 reads BUILD_UTC.
- R5: Offset 5 reads the sample of the most recent sens_temp_vld_i strobe, sign-extended to 32 bits; it changes only on a strobe.
- R6: sens_temp_req_o is a one-cycle pulse repeating every CLK_HZ cycles.
- R7: temp_alarm_o is high for exactly the one cycle after a strobe whose signed sample exceeds ALARM_DEGC*16; a sample equal to the threshold or negative gives no pulse.
- R8: Offset 6 reads power-good flags in bits [PG_N-1:0] and card presence in bit 16; all other bits read 0.
- R9: Offset 7 is read/write; after a write, vadj_code_o shows bits [31:16] and clk_sel_o bits [15:0] of the written word, and the word reads back unchanged.
- R10: Writes to offsets 0 to 6 have no effect on any register or output.
- R11: Each access (cyc and stb high) is acknowledged by a one-cycle wb_ack_o in the following cycle, with read data valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word offset |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| board_type_i | input | 16 | Board type straps |
| pcb_ver_i | input | 16 | PCB version straps |
| pwr_good_i | input | PG_N | Supply good flags |
| card_present_i | input | 1 | Mezzanine presence |
| sens_temp_req_o | output | 1 | Temperature read request pulse |
| sens_temp_vld_i | input | 1 | Temperature sample valid |
| sens_temp_i | input | TEMP_W | Signed temperature, 4 fraction bits |
| sens_id_vld_i | input | 1 | Silicon ID valid |
| sens_id_i | input | 64 | Silicon ID |
| vadj_code_o | output | 16 | Adjustable supply code |
| clk_sel_o | output | 16 | System clock selection |
| temp_alarm_o | output | 1 | Over-temperature pulse |

## Verification
The bench builds the block with CLK_HZ set to 40, so the one-second request period shrinks to 40 cycles and several full periods can be timed between bus traffic. PG_N is 3, which leaves bits 3 to 15 of the status word as unused positions the bench can check for zero. Temperature samples are random around the 960 threshold, plus the exact threshold, one above it and negative values, so both sides of the signed comparison are reached.

// File: rtl/carrier_regs_pkg.sv
package carrier_regs_pkg;

  localparam int WORD_W = 32;
  localparam int ADR_W  = 3;

  typedef enum logic [ADR_W-1:0] {
    OFS_CARRIER = 3'd0,
    OFS_ID_LO   = 3'd1,
    OFS_ID_HI   = 3'd2,
    OFS_BS_TYPE = 3'd3,
    OFS_BS_DATE = 3'd4,
    OFS_TEMP    = 3'd5,
    OFS_STATUS  = 3'd6,
    OFS_CONTROL = 3'd7
  } reg_ofs_e;

  localparam int STAT_PRESENT_BIT = 16;

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/csr_temp_poll.sv
module csr_temp_poll #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TEMP_W     = 16,
  parameter int FRAC_BITS  = 4,
  parameter int ALARM_DEGC = 60
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              temp_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              req_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic              alarm_o
);

  localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_HZ - 1);
  localparam logic signed [TEMP_W-1:0] LIMIT =
    TEMP_W'(ALARM_DEGC * (2 ** FRAC_BITS));

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              req_q, req_d;
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic              alarm_q, alarm_d;
  logic              wrap;
  logic              over;

  assign wrap = (cnt_q == CNT_LAST);
  assign over = ($signed(temp_i) > LIMIT);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    req_d   = wrap;
    temp_d  = temp_q;
    alarm_d = 1'b0;
    if (temp_vld_i) begin
      temp_d  = temp_i;
      alarm_d = over;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      req_q   <= 1'b0;
      temp_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      req_q   <= req_d;
      temp_q  <= temp_d;
      alarm_q <= alarm_d;
    end
  end

  assign req_o   = req_q;
  assign temp_o  = temp_q;
  assign alarm_o = alarm_q;

  generate
    if (CLK_HZ > 1) begin : g_req_chk
      assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        req_o |=> !req_o);
    end
  endgenerate

  assert_alarm_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    alarm_o |-> $past(temp_vld_i));

  assert_temp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !temp_vld_i |=> $stable(temp_o));

endmodule

// File: rtl/csr_id_latch.sv
module csr_id_latch #(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            id_vld_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] id_o
);

  logic [ID_W-1:0] id_q, id_d;
  logic            done_q, done_d;

  always_comb begin
    id_d   = id_q;
    done_d = done_q;
    if (id_vld_i && !done_q) begin
      id_d   = id_i;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      id_q   <= '0;
      done_q <= 1'b0;
    end else begin
      id_q   <= id_d;
      done_q <= done_d;
    end
  end

  assign id_o = id_q;

  assert_id_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |=> $stable(id_o));

endmodule

// File: rtl/csr_bus_regs.sv
module csr_bus_regs
  import carrier_regs_pkg::*;
#(
  parameter logic [WORD_W-1:0] CTRL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [WORD_W-1:0] dat_i,
  output logic [WORD_W-1:0] dat_o,
  output logic              ack_o,
  input  logic [WORD_W-1:0] carrier_w_i,
  input  logic [WORD_W-1:0] id_lo_w_i,
  input  logic [WORD_W-1:0] id_hi_w_i,
  input  logic [WORD_W-1:0] bs_type_w_i,
  input  logic [WORD_W-1:0] bs_date_w_i,
  input  logic [WORD_W-1:0] temp_w_i,
  input  logic [WORD_W-1:0] status_w_i,
  output logic [WORD_W-1:0] ctrl_o
);

  logic              ack_q, ack_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              take;
  logic [WORD_W-1:0] rd_mux;

  assign take = cyc_i && stb_i && !ack_q;

  always_comb begin
    unique case (reg_ofs_e'(adr_i))
      OFS_CARRIER: rd_mux = carrier_w_i;
      OFS_ID_LO:   rd_mux = id_lo_w_i;
      OFS_ID_HI:   rd_mux = id_hi_w_i;
      OFS_BS_TYPE: rd_mux = bs_type_w_i;
      OFS_BS_DATE: rd_mux = bs_date_w_i;
      OFS_TEMP:    rd_mux = temp_w_i;
      OFS_STATUS:  rd_mux = status_w_i;
      default:     rd_mux = ctrl_q;
    endcase
  end

  always_comb begin
    ack_d  = take;
    dat_d  = dat_q;
    ctrl_d = ctrl_q;
    if (take) begin
      dat_d = rd_mux;
      if (we_i && (reg_ofs_e'(adr_i) == OFS_CONTROL)) begin
        ctrl_d = dat_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ack_q  <= 1'b0;
      dat_q  <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      ack_q  <= ack_d;
      dat_q  <= dat_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign ctrl_o = ctrl_q;

  assert_ack_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ack_o |=> !ack_o);

  assert_ack_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cyc_i && stb_i && !ack_o) |=> ack_o);

  assert_ctrl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(cyc_i && stb_i && we_i && (adr_i == OFS_CONTROL)) |=> $stable(ctrl_o));

endmodule

// File: rtl/carrier_status_regs.sv
module carrier_status_regs
  import carrier_regs_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          TEMP_W     = 16,
  parameter int          FRAC_BITS  = 4,
  parameter int          ALARM_DEGC = 60,
  parameter int          PG_N       = 4,
  parameter logic [15:0] BS_TYPE    = 16'h00A1,
  parameter logic [15:0] BS_VER     = 16'h0001,
  parameter logic [31:0] BUILD_UTC  = 32'h4C8F_0000,
  parameter logic [31:0] CTRL_RST   = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [2:0]        wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic [15:0]       board_type_i,
  input  logic [15:0]       pcb_ver_i,
  input  logic [PG_N-1:0]   pwr_good_i,
  input  logic              card_present_i,
  output logic              sens_temp_req_o,
  input  logic              sens_temp_vld_i,
  input  logic [TEMP_W-1:0] sens_temp_i,
  input  logic              sens_id_vld_i,
  input  logic [63:0]       sens_id_i,
  output logic [15:0]       vadj_code_o,
  output logic [15:0]       clk_sel_o,
  output logic              temp_alarm_o
);

  localparam int EXT_W = WORD_W - TEMP_W;

  logic              rst_n;
  logic [TEMP_W-1:0] temp_val;
  logic [63:0]       id_val;
  logic [31:0]       ctrl_val;
  logic [31:0]       temp_word;
  logic [31:0]       status_word;

  csr_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  csr_temp_poll #(
    .CLK_HZ     (CLK_HZ),
    .TEMP_W     (TEMP_W),
    .FRAC_BITS  (FRAC_BITS),
    .ALARM_DEGC (ALARM_DEGC)
  ) u_temp (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .temp_vld_i (sens_temp_vld_i),
    .temp_i     (sens_temp_i),
    .req_o      (sens_temp_req_o),
    .temp_o     (temp_val),
    .alarm_o    (temp_alarm_o)
  );

  csr_id_latch #(
    .ID_W (64)
  ) u_id (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .id_vld_i (sens_id_vld_i),
    .id_i     (sens_id_i),
    .id_o     (id_val)
  );

  always_comb begin
    temp_word = {{EXT_W{temp_val[TEMP_W-1]}}, temp_val};
    status_word = '0;
    status_word[PG_N-1:0] = pwr_good_i;
    status_word[STAT_PRESENT_BIT] = card_present_i;
  end

  csr_bus_regs #(
    .CTRL_RST (CTRL_RST)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .cyc_i       (wb_cyc_i),
    .stb_i       (wb_stb_i),
    .we_i        (wb_we_i),
    .adr_i       (wb_adr_i),
    .dat_i       (wb_dat_i),
    .dat_o       (wb_dat_o),
    .ack_o       (wb_ack_o),
    .carrier_w_i ({board_type_i, pcb_ver_i}),
    .id_lo_w_i   (id_val[31:0]),
    .id_hi_w_i   (id_val[63:32]),
    .bs_type_w_i ({BS_TYPE, BS_VER}),
    .bs_date_w_i (BUILD_UTC),
    .temp_w_i    (temp_word),
    .status_w_i  (status_word),
    .ctrl_o      (ctrl_val)
  );

  assign vadj_code_o = ctrl_val[31:16];
  assign clk_sel_o   = ctrl_val[15:0];

  assert_outputs_track_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wb_cyc_i && wb_stb_i && wb_we_i) |=> ($stable(vadj_code_o) && $stable(clk_sel_o)));

endmodule

// File: tb/carrier_status_regs_test.sv
module carrier_status_regs_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          HZ         = 40;
  localparam int          PGN        = 3;
  localparam logic [15:0] BST        = 16'h5A5A;
  localparam logic [15:0] BSV        = 16'h0107;
  localparam logic [31:0] UTC        = 32'h6123_4567;
  localparam logic [31:0] CRST       = 32'h0003_0002;
  localparam int          LIMIT      = 960;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 0, stb = 0, we = 0;
  logic [2:0]  adr = 0;
  logic [31:0] wdat = 0;
  logic [31:0] rdat;
  logic        ack;
  logic [15:0] btype = 16'hC0DE, pver = 16'h0004;
  logic [PGN-1:0] pg = 3'b101;
  logic        pres = 1'b1;
  logic        treq;
  logic        tvld = 0;
  logic [15:0] tval = 0;
  logic        idvld = 0;
  logic [63:0] idval = 0;
  logic [15:0] vadj, csel;
  logic        alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_status_regs #(
    .CLK_HZ(HZ), .TEMP_W(16), .FRAC_BITS(4), .ALARM_DEGC(60), .PG_N(PGN),
    .BS_TYPE(BST), .BS_VER(BSV), .BUILD_UTC(UTC), .CTRL_RST(CRST)
  ) uut (
    .clk_i(clk), .rst_n_i(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .board_type_i(btype), .pcb_ver_i(pver), .pwr_good_i(pg),
    .card_present_i(pres), .sens_temp_req_o(treq),
    .sens_temp_vld_i(tvld), .sens_temp_i(tval),
    .sens_id_vld_i(idvld), .sens_id_i(idval),
    .vadj_code_o(vadj), .clk_sel_o(csel), .temp_alarm_o(alarm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_temp(input logic [15:0] t);
    return {{16{t[15]}}, t};
  endfunction

  function automatic logic exp_alarm(input logic [15:0] t);
    return $signed(t) > LIMIT;
  endfunction

  function automatic logic [31:0] exp_status(input logic [PGN-1:0] p, input logic c);
    logic [31:0] w;
    w = '0;
    w[PGN-1:0] = p;
    w[16] = c;
    return w;
  endfunction

  // One bus access; ack and read data are checked one cycle later (R11).
  task automatic bus(input logic w, input logic [2:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(negedge clk);
    chk("R11 ack", {31'd0, ack}, 32'd1);
    q = rdat;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk("R11 ack single", {31'd0, ack}, 32'd0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    bus(1'b0, a, 32'd0, q);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  task automatic temp_sample(input logic [15:0] t);
    logic [31:0] q;
    @(negedge clk);
    tvld = 1; tval = t;
    @(negedge clk);
    tvld = 0;
    chk("R7 alarm after sample", {31'd0, alarm}, {31'd0, exp_alarm(t)});
    tval = ~t;
    @(negedge clk);
    chk("R7 alarm one cycle", {31'd0, alarm}, 32'd0);
    rd(3'd5, q);
    chk("R5 temperature", q, exp_temp(t));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, ctl, ro_before;
    logic [63:0] id_a;
    int gap;
    void'($urandom(32'h0BAD_CAFE));

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ack", {31'd0, ack}, 32'd0);
    chk("R1 req", {31'd0, treq}, 32'd0);
    chk("R1 alarm", {31'd0, alarm}, 32'd0);
    chk("R1 control outputs", {vadj, csel}, CRST);
    rd(3'd5, q); chk("R1 temperature", q, 32'd0);
    rd(3'd1, q); chk("R1 id low", q, 32'd0);
    rd(3'd7, q); chk("R1 control word", q, CRST);

    // R2, R4, R8 identity and status words
    rd(3'd0, q); chk("R2 carrier", q, {btype, pver});
    btype = 16'h1234; pver = 16'hABCD;
    rd(3'd0, q); chk("R2 carrier straps", q, {btype, pver});
    rd(3'd3, q); chk("R4 bitstream type", q, {BST, BSV});
    rd(3'd4, q); chk("R4 build time", q, UTC);
    rd(3'd6, q); chk("R8 status", q, exp_status(pg, pres));
    pg = 3'b010; pres = 0;
    rd(3'd6, q); chk("R8 status change", q, exp_status(pg, pres));

    // R3 silicon ID captured once
    id_a = 64'hFEDC_BA98_7654_3210;
    @(negedge clk); idvld = 1; idval = id_a;
    @(negedge clk); idvld = 0;
    rd(3'd1, q); chk("R3 id low", q, id_a[31:0]);
    rd(3'd2, q); chk("R3 id high", q, id_a[63:32]);
    @(negedge clk); idvld = 1; idval = 64'h1111_2222_3333_4444;
    @(negedge clk); idvld = 0;
    rd(3'd1, q); chk("R3 id low frozen", q, id_a[31:0]);
    rd(3'd2, q); chk("R3 id high frozen", q, id_a[63:32]);

    // R7 directed corners and R5
    temp_sample(16'd960);
    temp_sample(16'd961);
    temp_sample(16'hFF00);
    temp_sample(16'h7FFF);
    temp_sample(16'h8000);
    temp_sample(16'd959);

    // R5 and R7 random samples around the threshold
    for (int i = 0; i < 30; i++) begin
      logic [15:0] t;
      t = 16'(900 + int'($urandom_range(120)));
      if ((i % 5) == 0) t = 16'($urandom);
      temp_sample(t);
    end

    // R9 control read/write with random values
    for (int i = 0; i < 8; i++) begin
      ctl = $urandom;
      wr(3'd7, ctl);
      chk("R9 vadj output", {16'd0, vadj}, {16'd0, ctl[31:16]});
      chk("R9 clock select output", {16'd0, csel}, {16'd0, ctl[15:0]});
      rd(3'd7, q); chk("R9 readback", q, ctl);
    end

    // R10 writes to read-only words ignored
    for (int a = 0; a < 7; a++) begin
      case (a)
        0: ro_before = {btype, pver};
        1: ro_before = id_a[31:0];
        2: ro_before = id_a[63:32];
        3: ro_before = {BST, BSV};
        4: ro_before = UTC;
        5: ro_before = exp_temp(16'd959);
        default: ro_before = exp_status(pg, pres);
      endcase
      if (a == 5) temp_sample(16'd959);
      wr(3'(a), $urandom);
      rd(3'(a), q); chk("R10 read-only word", q, ro_before);
      chk("R10 control unchanged", {vadj, csel}, ctl);
    end

    // R6 request period and width
    @(negedge clk);
    while (!treq) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 request width", {31'd0, treq}, 32'd0);
      gap = 1;
      while (!treq) begin
        @(negedge clk);
        gap++;
      end
      chk("R6 request period", gap, HZ);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule